// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running phase of a colour subcarrier, one step per active pixel. A coarse phase accumulator adds a fixed increment on every pixel. Exact broadcast subcarrier frequencies are not whole fractions of the pixel clock, so a chain of up to two modulo accumulators supplies the missing fraction. Each modulo accumulator has a programmable rollover and sends one extra least-significant unit to the stage above it whenever it wraps. The phase word is meant for a sine lookup and modulator further down the video path. That path also receives an 8-bit burst amplitude, which this block passes through unchanged.

Any phase error that builds up over a long run is bounded by clearing every accumulator at a field start. The clear happens once every 2, 4 or 8 fields, or never, as the interval select chooses. As examples, an NTSC-style setting uses only the first modulo stage (rollover 27456, increment 20800, coarse increment 135, clear every 4 fields). A PAL-style setting uses both modulo stages (rollovers 27648 and 625, increments 4122 and 67, coarse increment 168, clear every 8 fields).

Top module: `scp_phase_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `phase` is 0. Reset is synchronous and active high.
- R2: At a clock edge where a pixel step is applied and `coarse_en` is high, `phase` becomes (phase + `coarse_inc` + c) mod 2^PHASE_W. Here c is the carry from the middle stage, either 0 or 1.
- R3: When `mid_en` is high, each pixel step adds `mid_inc`, plus the carry from the fine stage, to the middle accumulator modulo `mid_size`. A wrap (sum >= `mid_size`) gives a carry of 1 into the coarse phase in the same step.
- R4: When the fine stage is active, each pixel step adds `fine_inc` to the fine accumulator modulo `fine_size`. A wrap gives a carry of 1 into the middle stage in the same step.
- R5: The fine stage is active only when `fine_en` is high and `fine_size` is non-zero. With `fine_size` = 0 it has no effect on `phase`.
- R6: A stage whose enable is low keeps its value and gives no carry. With `pix_en` low and no clear due, `phase` keeps its value.
- R7: `clr_sel` sets the clear interval: 0 clears at every 2nd field start, 1 at every 4th, 2 at every 8th, and 3 never. Field starts are counted from reset or from the last clear.
- R8: At a field start where a clear is due, all three accumulators become 0, even if `pix_en` is high in the same cycle. A field start where no clear is due does not stop the pixel step in that cycle.
- R9: `burst_amp` always equals `burst_level`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel step enable |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| coarse_en | input | 1 | Coarse phase accumulator enable |
| mid_en | input | 1 | Middle modulo stage enable |
| fine_en | input | 1 | Fine modulo stage enable |
| clr_sel | input | 2 | Clear interval select (0:2, 1:4, 2:8 fields, 3:never) |
| coarse_inc | input | INC_W (12) | Coarse phase increment |
| mid_inc | input | MOD_W (15) | Middle stage increment |
| mid_size | input | MOD_W (15) | Middle stage rollover |
| fine_inc | input | MOD_W (15) | Fine stage increment |
| fine_size | input | MOD_W (15) | Fine stage rollover |
| burst_level | input | 8 | Burst peak amplitude |
| phase | output | PHASE_W (16) | Subcarrier phase word |
| burst_amp | output | 8 | Burst amplitude passthrough |

## Verification
The bench sweeps small rollovers through every increment below them, with both modulo stages running at once. This exposes a carry taken one step late or wrapped at the wrong threshold: the phase would drift by one unit at each wrap. Each clear interval is run over many fields, with pixels in the same cycle as every field start. An off-by-one field counter would clear one field early or late, and clear-versus-pixel priority done the wrong way round would leave a nonzero phase after a clear. Two further cases catch specific faults. If the fine stage ignored a zero rollover, it would inject a carry on every pixel. If a disabled stage leaked its carry, the phase would advance while that stage is off.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        CLR_EVERY2 = 2'd0,
        CLR_EVERY4 = 2'd1,
        CLR_EVERY8 = 2'd2,
        CLR_NEVER  = 2'd3
    } clr_sel_e;

    localparam int unsigned FIELD_CNT_W = 3;

    // Mask of field-counter bits that must all be set for a clear to be due.
    function automatic logic [FIELD_CNT_W-1:0] due_mask(clr_sel_e sel);
        case (sel)
            CLR_EVERY2: due_mask = 3'b001;
            CLR_EVERY4: due_mask = 3'b011;
            CLR_EVERY8: due_mask = 3'b111;
            default:    due_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/scp_mod_acc.sv
module scp_mod_acc #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic         en,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] size,
    input  logic         cin,
    output logic         cout
);
    localparam int unsigned SW = W + 1;

    logic [W-1:0]  acc_q;
    logic [SW-1:0] sum;
    logic          wrap;
    logic [SW-1:0] nxt;

    always_comb begin
        sum  = SW'(acc_q) + SW'(inc) + SW'(cin);
        wrap = (sum >= SW'(size));
        nxt  = wrap ? (sum - SW'(size)) : sum;
        cout = step && en && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step && en) begin
            acc_q <= nxt[W-1:0];
        end
    end

endmodule

// File: rtl/scp_field_seq.sv
module scp_field_seq
    import scp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     field_start,
    input  clr_sel_e sel,
    output logic     clr_due
);
    logic [FIELD_CNT_W-1:0] cnt_q;
    logic [FIELD_CNT_W-1:0] mask;

    always_comb begin
        mask    = due_mask(sel);
        clr_due = field_start && (sel != CLR_NEVER) && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (field_start) begin
            cnt_q <= clr_due ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scp_phase_acc.sv
module scp_phase_acc #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned INC_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               step,
    input  logic               en,
    input  logic [INC_W-1:0]   inc,
    input  logic               cin,
    output logic [PHASE_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (step && en) begin
            phase <= phase + PHASE_W'(inc) + PHASE_W'(cin);
        end
    end

endmodule

// File: rtl/scp_phase_gen.sv
module scp_phase_gen
    import scp_pkg::*;
#(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned INC_W   = 12,
    parameter int unsigned MOD_W   = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_en,
    input  logic               field_start,
    input  logic               coarse_en,
    input  logic               mid_en,
    input  logic               fine_en,
    input  logic [1:0]         clr_sel,
    input  logic [INC_W-1:0]   coarse_inc,
    input  logic [MOD_W-1:0]   mid_inc,
    input  logic [MOD_W-1:0]   mid_size,
    input  logic [MOD_W-1:0]   fine_inc,
    input  logic [MOD_W-1:0]   fine_size,
    input  logic [7:0]         burst_level,
    output logic [PHASE_W-1:0] phase,
    output logic [7:0]         burst_amp
);
    localparam int unsigned NSTAGE = 2;

    logic                 clr_due;
    logic [MOD_W-1:0]     stg_inc  [NSTAGE];
    logic [MOD_W-1:0]     stg_size [NSTAGE];
    logic                 stg_en   [NSTAGE];
    logic [NSTAGE:0]      carry;

    scp_field_seq u_field (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .sel         (clr_sel_e'(clr_sel)),
        .clr_due     (clr_due)
    );

    // stage 0 = middle, stage 1 = fine; each feeds the one below it
    always_comb begin
        stg_inc[0]  = mid_inc;
        stg_size[0] = mid_size;
        stg_en[0]   = mid_en;
        stg_inc[1]  = fine_inc;
        stg_size[1] = fine_size;
        stg_en[1]   = fine_en && (fine_size != '0);
    end

    assign carry[NSTAGE] = 1'b0;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        scp_mod_acc #(.W(MOD_W)) u_acc (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_due),
            .step (pix_en),
            .en   (stg_en[k]),
            .inc  (stg_inc[k]),
            .size (stg_size[k]),
            .cin  (carry[k+1]),
            .cout (carry[k])
        );
    end

    scp_phase_acc #(.PHASE_W(PHASE_W), .INC_W(INC_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_due),
        .step  (pix_en),
        .en    (coarse_en),
        .inc   (coarse_inc),
        .cin   (carry[0]),
        .phase (phase)
    );

    assign burst_amp = burst_level;

endmodule

// File: rtl/scp_phase_gen_chk.sv
module scp_phase_gen_chk #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned INC_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               pix_en,
    input logic               field_start,
    input logic               coarse_en,
    input logic               mid_en,
    input logic [1:0]         clr_sel,
    input logic [INC_W-1:0]   coarse_inc,
    input logic [PHASE_W-1:0] phase,
    input logic               clr_due
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> phase == '0);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pix_en && !field_start) |=> $stable(phase));

    // R6
    coarse_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!coarse_en && !field_start) |=> $stable(phase));

    // R2
    coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_en && coarse_en && !mid_en && !field_start) |=>
        phase == PHASE_W'($past(phase) + PHASE_W'($past(coarse_inc))));

    // R7
    never_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_sel == 2'd3) |-> !clr_due);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_due |=> phase == '0);

endmodule

bind scp_phase_gen scp_phase_gen_chk #(.PHASE_W(PHASE_W), .INC_W(INC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_en      (pix_en),
    .field_start (field_start),
    .coarse_en   (coarse_en),
    .mid_en      (mid_en),
    .clr_sel     (clr_sel),
    .coarse_inc  (coarse_inc),
    .phase       (phase),
    .clr_due     (clr_due)
);

// File: tb/scp_phase_gen_tb_top.sv
module scp_phase_gen_tb_top;
    localparam int PHASE_W = 16;
    localparam int INC_W   = 12;
    localparam int MOD_W   = 15;
    localparam int PMOD    = 1 << PHASE_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pix_en = 1'b0;
    logic               field_start = 1'b0;
    logic               coarse_en = 1'b0;
    logic               mid_en = 1'b0;
    logic               fine_en = 1'b0;
    logic [1:0]         clr_sel = 2'd3;
    logic [INC_W-1:0]   coarse_inc = '0;
    logic [MOD_W-1:0]   mid_inc = '0;
    logic [MOD_W-1:0]   mid_size = '0;
    logic [MOD_W-1:0]   fine_inc = '0;
    logic [MOD_W-1:0]   fine_size = '0;
    logic [7:0]         burst_level = '0;
    logic [PHASE_W-1:0] phase;
    logic [7:0]         burst_amp;

    int checks = 0;
    int errors = 0;
    int m_ph, m_mid, m_fine, m_fcnt;
    logic lfsr_bit;
    logic [7:0] lfsr = 8'h5a;

    always #2.5 clk = ~clk;

    scp_phase_gen #(.PHASE_W(PHASE_W), .INC_W(INC_W), .MOD_W(MOD_W)) dut_i (
        .clk(clk), .rst(rst), .pix_en(pix_en), .field_start(field_start),
        .coarse_en(coarse_en), .mid_en(mid_en), .fine_en(fine_en),
        .clr_sel(clr_sel), .coarse_inc(coarse_inc), .mid_inc(mid_inc),
        .mid_size(mid_size), .fine_inc(fine_inc), .fine_size(fine_size),
        .burst_level(burst_level), .phase(phase), .burst_amp(burst_amp)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of one clock edge, written from the requirements.
    task automatic model_edge(bit fs, bit pe);
        int mask, s, c_fine, c_mid;
        bit clr;
        mask = (clr_sel == 0) ? 1 : (clr_sel == 1) ? 3 : 7;
        clr = fs && (clr_sel != 3) && ((m_fcnt & mask) == mask);
        if (fs) m_fcnt = clr ? 0 : ((m_fcnt + 1) % 8);
        if (clr) begin
            m_ph = 0; m_mid = 0; m_fine = 0;
        end else if (pe) begin
            c_fine = 0;
            if (fine_en && fine_size != 0) begin
                s = m_fine + fine_inc;
                if (s >= fine_size) begin s -= fine_size; c_fine = 1; end
                m_fine = s;
            end
            c_mid = 0;
            if (mid_en) begin
                s = m_mid + mid_inc + c_fine;
                if (s >= mid_size) begin s -= mid_size; c_mid = 1; end
                m_mid = s;
            end
            if (coarse_en) m_ph = (m_ph + coarse_inc + c_mid) % PMOD;
        end
    endtask

    task automatic cyc(string req, bit fs, bit pe);
        field_start = fs;
        pix_en      = pe;
        @(posedge clk);
        model_edge(fs, pe);
        @(negedge clk);
        field_start = 1'b0;
        pix_en      = 1'b0;
        check(req, int'(phase), m_ph);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_ph = 0; m_mid = 0; m_fine = 0; m_fcnt = 0;
    endtask

    task automatic cfg(int ci, int mi, int ms, int fi, int fsz,
                       bit ce, bit me, bit fe, int sel);
        coarse_inc = INC_W'(ci);
        mid_inc    = MOD_W'(mi);
        mid_size   = MOD_W'(ms);
        fine_inc   = MOD_W'(fi);
        fine_size  = MOD_W'(fsz);
        coarse_en  = ce;
        mid_en     = me;
        fine_en    = fe;
        clr_sel    = 2'(sel);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1", int'(phase), 0);
        do_reset();
        check("R1", int'(phase), 0);

        // R9: burst amplitude passthrough over every level
        for (int b = 0; b < 256; b++) begin
            burst_level = 8'(b);
            #1;
            check("R9", int'(burst_amp), b);
        end

        // R2: coarse accumulator alone, including wrap of the phase word
        cfg(4095, 0, 1, 0, 0, 1, 0, 0, 3);
        for (int i = 0; i < 40; i++) cyc("R2", 0, 1);

        // R3: NTSC-style setting, middle stage only
        do_reset();
        cfg(135, 20800, 27456, 0, 0, 1, 1, 0, 3);
        for (int i = 0; i < 3000; i++) cyc("R3", 0, 1);

        // R4: PAL-style setting, both modulo stages
        do_reset();
        cfg(168, 4122, 27648, 67, 625, 1, 1, 1, 3);
        for (int i = 0; i < 3000; i++) cyc("R4", 0, 1);

        // R3 R4: sweep small rollovers through every increment
        for (int ms = 2; ms <= 6; ms++)
            for (int mi = 0; mi < ms; mi++)
                for (int fi = 0; fi < 4; fi++) begin
                    do_reset();
                    cfg(3, mi, ms, fi, 4, 1, 1, 1, 3);
                    for (int i = 0; i < 24; i++) cyc("R4_sweep", 0, 1);
                end

        // R5: fine stage enabled but size zero has no effect
        do_reset();
        cfg(7, 5, 9, 3, 0, 1, 1, 1, 3);
        for (int i = 0; i < 60; i++) cyc("R5", 0, 1);

        // R6: disabled middle stage yields no carry; irregular pixel gaps hold
        do_reset();
        cfg(11, 6, 7, 2, 3, 1, 0, 1, 3);
        for (int i = 0; i < 60; i++) cyc("R6", 0, 1);
        cfg(11, 6, 7, 2, 3, 1, 1, 1, 3);
        for (int i = 0; i < 200; i++) begin
            lfsr_bit = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
            lfsr = {lfsr[6:0], lfsr_bit};
            cyc("R6_gap", 0, lfsr[0]);
        end
        coarse_en = 1'b0;
        for (int i = 0; i < 20; i++) cyc("R6_coarse_off", 0, 1);

        // R7 R8: every clear interval, pixel in the field-start cycle
        for (int sel = 0; sel < 4; sel++) begin
            do_reset();
            cfg(5, 3, 7, 2, 5, 1, 1, 1, sel);
            for (int f = 0; f < 20; f++) begin
                for (int p = 0; p < 3; p++) cyc("R7", 0, 1);
                cyc("R8", 1, 1);
            end
            // field starts with no pixel between them
            for (int f = 0; f < 9; f++) cyc("R7_back", 1, (f % 2) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule